// File: doc/BRIEF.md
# Modbus RTU Exception Responder

This block sits after a Modbus RTU receiver that has already split a request into its fields. For each accepted request it decides one of four outcomes. The request can be dropped unheard, answered normally, answered with an exception frame, or handled quietly because it was a broadcast. Only in the exception case does it produce bytes itself. The normal reply payload and the register storage belong to neighbouring blocks. Those blocks act on the `verdict` reported with the one-cycle `done` pulse.

For the two supported functions (read holding registers, 0x03, and write multiple registers, 0x10), the block walks the requested register range one address per clock. It uses a combinational lookup port into the register map. An address error is reported only when no register in the range is reachable in the requested direction. Missing registers, and registers with the wrong permission, are skipped and left to the payload logic: they read as zero and writes to them are discarded. The walk stops at the first reachable register.

Exception frames leave on a byte stream with valid/ready handshaking. Once `tx_valid` is high, it stays high and `tx_data` stays unchanged until a cycle in which `tx_ready` is high. A byte is taken on each rising edge where both are high. `tx_ready` may be held low for any number of cycles. `req_valid` is honoured only while `busy` is low.

Top module: `mb_exc_gen`

## Requirements
- R1: A request captured with any bit of `link_err` set (parity, CRC, overrun, framing, busy) ends with `verdict` = 0 (drop) and no frame, whatever its other fields.
- R2: A request whose slave address is neither 0 nor `OWN_ADDR` ends with `verdict` = 0 (drop) and no frame.
- R3: A function code other than 0x03 and 0x10 gives `verdict` = 2 with `exc_code` = 0x01. `done` rises two cycles after the capturing edge.
- R4: A register count of 0, or above 125 for 0x03, or above 123 for 0x10, gives `exc_code` = 0x03. This check applies only when the function check passes.
- R5: When some register in the range is reachable in the requested direction, `verdict` = 1 (normal). Reachable means it exists and is readable for 0x03, or exists and is writable for 0x10. `done` comes k+3 cycles after capture, where k is the offset of the first reachable register.
- R6: When no register in the range is reachable, `verdict` = 2 with `exc_code` = 0x02. `done` comes count+2 cycles after capture.
- R7: A request to slave address 0 ends with `verdict` = 3 (quiet) and never produces a frame, even when it would otherwise raise an exception.
- R8: An exception frame is five bytes, in this order:
  - the slave address;
  - the function code OR 0x80;
  - the exception code;
  - the CRC-16 low byte, then its high byte.
  The CRC uses initial value 0xFFFF and the reflected polynomial 0xA001, and covers the first three bytes.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change on the next cycle.
- R10: `done` is high for exactly one cycle per accepted request. `tx_valid` first rises in the cycle after `done`.
- R11: `req_valid` is ignored while `busy` is high. Such a request changes neither the outcome in progress nor produces a later `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request fields are valid; captured when `busy` is low |
| req_slave | input | 8 | Received slave address |
| req_func | input | 8 | Received function code |
| req_start | input | 16 | First register address |
| req_count | input | 16 | Number of registers |
| link_err | input | 5 | Receiver error flags; any set bit drops the request |
| map_addr | output | 16 | Register address being looked up |
| map_exists | input | 1 | Register at `map_addr` exists |
| map_rd_ok | input | 1 | Register at `map_addr` may be read |
| map_wr_ok | input | 1 | Register at `map_addr` may be written |
| busy | output | 1 | A request is being processed or its frame sent |
| done | output | 1 | One-cycle pulse: `verdict` and `exc_code` are final |
| verdict | output | 2 | 0 drop, 1 normal, 2 exception, 3 quiet broadcast |
| exc_code | output | 8 | Exception code when `verdict` is 2, else 0 |
| tx_valid | output | 1 | Exception frame byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Exception frame byte |

## Verification
The hardest outcomes to reach are at the edges of the walk. One is a range that contains only registers that exist but have the wrong permission, so an address error must still be raised. The other is a range whose only reachable register is the last one. The bench's register map has a read-protected window, a write-protected window, a hole and a small island past 0xFF. Ranges are placed to straddle these features, so the first hit falls at offsets 0, 2, 6 and 8, or nowhere. A second request is also pushed in mid-walk, and frames are drained under several stall patterns on the ready line.

// File: rtl/mb_exc_pkg.sv
package mb_exc_pkg;
  typedef enum logic [1:0] {
    VERD_DROP   = 2'd0,
    VERD_NORMAL = 2'd1,
    VERD_EXCEPT = 2'd2,
    VERD_QUIET  = 2'd3
  } verdict_e;

  localparam logic [7:0]  FN_READ_HOLD   = 8'h03;
  localparam logic [7:0]  FN_WRITE_MULTI = 8'h10;
  localparam logic [7:0]  EXC_BAD_FUNC   = 8'h01;
  localparam logic [7:0]  EXC_BAD_ADDR   = 8'h02;
  localparam logic [7:0]  EXC_BAD_DATA   = 8'h03;
  localparam logic [7:0]  FN_ERR_FLAG    = 8'h80;
  localparam logic [15:0] CRC_SEED       = 16'hFFFF;
  localparam logic [15:0] CRC_POLY       = 16'hA001;

  function automatic logic [15:0] crc16_byte(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/mb_req_screen.sv
module mb_req_screen
  import mb_exc_pkg::*;
#(
  parameter logic [7:0] OWN_ADDR   = 8'h11,
  parameter int         CW         = 16,
  parameter int         MAX_RD_CNT = 125,
  parameter int         MAX_WR_CNT = 123,
  parameter int         NERR       = 5
) (
  input  logic [7:0]    slave,
  input  logic [7:0]    func,
  input  logic [CW-1:0] count,
  input  logic [NERR-1:0] link_err,
  output logic          drop,
  output logic          bcast,
  output logic          is_write,
  output logic          early_exc,
  output logic [7:0]    early_code
);
  logic func_ok, cnt_bad;
  logic [CW-1:0] cnt_max;

  always_comb begin
    bcast    = (slave == 8'h00);
    drop     = (|link_err) || (!bcast && slave != OWN_ADDR);
    is_write = (func == FN_WRITE_MULTI);
    func_ok  = (func == FN_READ_HOLD) || is_write;
    cnt_max  = is_write ? CW'(MAX_WR_CNT) : CW'(MAX_RD_CNT);
    cnt_bad  = (count == '0) || (count > cnt_max);
    early_exc  = !func_ok || cnt_bad;
    early_code = !func_ok ? EXC_BAD_FUNC : EXC_BAD_DATA;
  end
endmodule

// File: rtl/mb_range_walker.sv
module mb_range_walker #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          is_write,
  output logic [AW-1:0] map_addr,
  input  logic          map_exists,
  input  logic          map_rd_ok,
  input  logic          map_wr_ok,
  output logic          finish,
  output logic          found
);
  logic          active;
  logic [CW-1:0] idx;
  logic          reach, last;

  always_comb begin
    map_addr = base + AW'(idx);
    reach    = map_exists && (is_write ? map_wr_ok : map_rd_ok);
    last     = (idx == count - CW'(1));
    finish   = active && (reach || last);
    found    = active && reach;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (finish) begin
      active <= 1'b0;
    end else if (active) begin
      idx    <= idx + CW'(1);
    end
  end
endmodule

// File: rtl/mb_exc_tx.sv
module mb_exc_tx
  import mb_exc_pkg::*;
#(
  parameter int FRAME_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] slave,
  input  logic [7:0] func,
  input  logic [7:0] code,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       last_take
);
  localparam int BIW = $clog2(FRAME_LEN);

  logic           sending;
  logic [BIW-1:0] bi;
  logic [7:0]     b_slv, b_fn, b_code;
  logic [15:0]    crc_r, crc_new;
  logic [7:0]     fn_err;

  always_comb begin
    fn_err  = func | FN_ERR_FLAG;
    crc_new = crc16_byte(crc16_byte(crc16_byte(CRC_SEED, slave), fn_err), code);
    unique case (bi)
      BIW'(0):  tx_data = b_slv;
      BIW'(1):  tx_data = b_fn;
      BIW'(2):  tx_data = b_code;
      BIW'(3):  tx_data = crc_r[7:0];
      default:  tx_data = crc_r[15:8];
    endcase
    tx_valid  = sending;
    last_take = sending && tx_ready && (bi == BIW'(FRAME_LEN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending <= 1'b0;
      bi      <= '0;
      b_slv   <= '0;
      b_fn    <= '0;
      b_code  <= '0;
      crc_r   <= '0;
    end else if (load) begin
      sending <= 1'b1;
      bi      <= '0;
      b_slv   <= slave;
      b_fn    <= fn_err;
      b_code  <= code;
      crc_r   <= crc_new;
    end else if (last_take) begin
      sending <= 1'b0;
      bi      <= '0;
    end else if (sending && tx_ready) begin
      bi      <= bi + BIW'(1);
    end
  end
endmodule

// File: rtl/mb_exc_gen.sv
module mb_exc_gen
  import mb_exc_pkg::*;
#(
  parameter logic [7:0] OWN_ADDR   = 8'h11,
  parameter int         AW         = 16,
  parameter int         CW         = 16,
  parameter int         MAX_RD_CNT = 125,
  parameter int         MAX_WR_CNT = 123,
  parameter int         NERR       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [7:0]      req_slave,
  input  logic [7:0]      req_func,
  input  logic [AW-1:0]   req_start,
  input  logic [CW-1:0]   req_count,
  input  logic [NERR-1:0] link_err,
  output logic [AW-1:0]   map_addr,
  input  logic            map_exists,
  input  logic            map_rd_ok,
  input  logic            map_wr_ok,
  output logic            busy,
  output logic            done,
  output logic [1:0]      verdict,
  output logic [7:0]      exc_code,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [7:0]      tx_data
);
  typedef enum logic [2:0] {ST_IDLE, ST_EVAL, ST_WALK, ST_FIN, ST_SEND} state_e;

  state_e          state;
  verdict_e        verd_r;
  logic [7:0]      code_r;
  logic [7:0]      r_slave, r_func;
  logic [AW-1:0]   r_start;
  logic [CW-1:0]   r_count;
  logic [NERR-1:0] r_link;

  logic       s_drop, s_bcast, s_write, s_exc;
  logic [7:0] s_code;
  logic       w_start, w_finish, w_found;
  logic       tx_load, tx_last;

  mb_req_screen #(
    .OWN_ADDR(OWN_ADDR), .CW(CW), .MAX_RD_CNT(MAX_RD_CNT),
    .MAX_WR_CNT(MAX_WR_CNT), .NERR(NERR)
  ) u_screen (
    .slave(r_slave), .func(r_func), .count(r_count), .link_err(r_link),
    .drop(s_drop), .bcast(s_bcast), .is_write(s_write),
    .early_exc(s_exc), .early_code(s_code)
  );

  assign w_start = (state == ST_EVAL) && !s_drop && !s_exc;

  mb_range_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(w_start), .base(r_start),
    .count(r_count), .is_write(s_write), .map_addr(map_addr),
    .map_exists(map_exists), .map_rd_ok(map_rd_ok), .map_wr_ok(map_wr_ok),
    .finish(w_finish), .found(w_found)
  );

  assign tx_load = (state == ST_FIN) && (verd_r == VERD_EXCEPT);

  mb_exc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .slave(r_slave),
    .func(r_func), .code(code_r), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .last_take(tx_last)
  );

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign verdict  = verd_r;
  assign exc_code = code_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      verd_r  <= VERD_DROP;
      code_r  <= '0;
      r_slave <= '0;
      r_func  <= '0;
      r_start <= '0;
      r_count <= '0;
      r_link  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          r_slave <= req_slave;
          r_func  <= req_func;
          r_start <= req_start;
          r_count <= req_count;
          r_link  <= link_err;
          state   <= ST_EVAL;
        end
        ST_EVAL: begin
          if (s_drop) begin
            verd_r <= VERD_DROP;
            code_r <= '0;
            state  <= ST_FIN;
          end else if (s_exc) begin
            verd_r <= s_bcast ? VERD_QUIET : VERD_EXCEPT;
            code_r <= s_bcast ? 8'h00 : s_code;
            state  <= ST_FIN;
          end else begin
            state  <= ST_WALK;
          end
        end
        ST_WALK: if (w_finish) begin
          if (s_bcast)      begin verd_r <= VERD_QUIET;  code_r <= '0; end
          else if (w_found) begin verd_r <= VERD_NORMAL; code_r <= '0; end
          else              begin verd_r <= VERD_EXCEPT; code_r <= EXC_BAD_ADDR; end
          state <= ST_FIN;
        end
        ST_FIN:  state <= (verd_r == VERD_EXCEPT) ? ST_SEND : ST_IDLE;
        ST_SEND: if (tx_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mb_exc_gen_chk.sv
module mb_exc_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] verdict,
  input logic [7:0] exc_code,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data
);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  tx_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(done));

  // R1 R2 R7
  no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && verdict != 2'd2 |=> !tx_valid);

  // R3 R4 R6
  exc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && verdict == 2'd2 |-> exc_code inside {8'h01, 8'h02, 8'h03});

  // R11
  tx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);
endmodule

bind mb_exc_gen mb_exc_gen_chk u_chk (.*);

// File: tb/tb_mb_exc_gen.sv
module tb_mb_exc_gen;
  localparam logic [7:0] OWN = 8'h11;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [7:0] req_slave = 0, req_func = 0;
  logic [15:0] req_start = 0, req_count = 0;
  logic [4:0] link_err = 0;
  logic [15:0] map_addr;
  logic map_exists, map_rd_ok, map_wr_ok;
  logic busy, done, tx_valid, tx_ready = 0;
  logic [1:0] verdict;
  logic [7:0] exc_code, tx_data;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mb_exc_gen dut (.*);

  // Register map model: 0x00-0x3F and 0x100-0x103 exist;
  // 0x10-0x17 not readable, 0x20-0x2F not writable.
  function automatic bit ex(int a);
    return (a < 'h40) || (a >= 'h100 && a < 'h104);
  endfunction
  function automatic bit rdok(int a);
    return ex(a) && !(a >= 'h10 && a <= 'h17);
  endfunction
  function automatic bit wrok(int a);
    return ex(a) && !(a >= 'h20 && a <= 'h2F);
  endfunction
  always_comb begin
    map_exists = ex(int'(map_addr));
    map_rd_ok  = rdok(int'(map_addr));
    map_wr_ok  = wrok(int'(map_addr));
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) begin
      c ^= {8'h00, q[i]};
      repeat (8) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  // stall: bit i of pattern = tx_ready in i-th byte cycle (wraps at 8)
  task automatic run(string tag, logic [7:0] sl, logic [7:0] fn, int st, int cnt,
                     logic [4:0] le, logic [7:0] stall, bit inject);
    int ev, ec, lat, k, idx, n;
    bit wr, hit;
    logic [7:0] q[$];
    logic [15:0] c;
    wr = (fn == 8'h10);
    ec = 0;
    if (le != 0 || (sl != 0 && sl != OWN)) begin ev = 0; lat = 2; end
    else begin
      if (fn != 8'h03 && fn != 8'h10) begin ev = 2; ec = 1; lat = 2; end
      else if (cnt == 0 || cnt > (wr ? 123 : 125)) begin ev = 2; ec = 3; lat = 2; end
      else begin
        hit = 0;
        for (k = 0; k < cnt; k++) begin
          int a = (st + k) & 'hFFFF;
          if (wr ? wrok(a) : rdok(a)) begin hit = 1; break; end
        end
        if (hit) begin ev = 1; lat = 3 + k; end
        else begin ev = 2; ec = 2; lat = 2 + cnt; end
      end
      if (sl == 0) begin ev = 3; ec = 0; end
    end
    req_valid = 1; req_slave = sl; req_func = fn;
    req_start = st[15:0]; req_count = cnt[15:0]; link_err = le;
    for (n = 1; n <= lat; n++) begin
      @(negedge clk);
      if (inject && n == 2) begin
        req_valid = 1; req_slave = OWN; req_func = 8'h07; link_err = 0; // R11
      end else req_valid = 0;
      if (n < lat) chk(!done, {tag, " early done"}, done, 0);
    end
    chk(done, {tag, " done timing"}, done, 1);
    chk(verdict == ev[1:0], {tag, " verdict"}, verdict, ev);
    chk(exc_code == ec[7:0], {tag, " code"}, exc_code, ec);
    chk(!tx_valid, "R10 no tx during done", tx_valid, 0);
    if (ev == 2) begin
      q = {sl, fn | 8'h80, ec[7:0]};
      c = crc_of(q);
      q.push_back(c[7:0]); q.push_back(c[15:8]);
      idx = 0;
      for (int i = 0; i < 60 && idx < 5; i++) begin
        @(negedge clk);
        chk(tx_valid, "R10/R9 tx_valid", tx_valid, 1);
        chk(tx_data == q[idx], $sformatf("R8 %s byte%0d", tag, idx), tx_data, q[idx]);
        tx_ready = stall[i % 8];
        if (tx_ready) idx++;
      end
    end
    @(negedge clk);
    tx_ready = 0;
    chk(!tx_valid, "R1/R2/R7 no frame after", tx_valid, 0);
    chk(!busy, {tag, " back idle"}, busy, 0);
    if (inject) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!done && !busy, "R11 ignored request", done, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !tx_valid && !busy && verdict == 0, "reset state", {done, tx_valid, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    run("R5 read hit k0", OWN, 8'h03, 'h05, 3, 0, 8'hFF, 0);
    run("R5 read skip protected", OWN, 8'h03, 'h12, 10, 0, 8'hFF, 0);
    run("R6 read all protected", OWN, 8'h03, 'h10, 8, 0, 8'b1010_0110, 0);
    run("R6 write all protected", OWN, 8'h10, 'h20, 16, 0, 8'b0101_0101, 0);
    run("R5 write skip protected", OWN, 8'h10, 'h28, 10, 0, 8'hFF, 0);
    run("R6 read hole", OWN, 8'h03, 'h40, 32, 0, 8'b0000_0001, 0);
    run("R5 read island", OWN, 8'h03, 'hFE, 3, 0, 8'hFF, 0);
    run("R3 bad func", OWN, 8'h06, 0, 1, 0, 8'b1100_1100, 0);
    run("R4 R3 priority", OWN, 8'h2B, 0, 0, 0, 8'hFF, 0);
    run("R4 zero count", OWN, 8'h03, 0, 0, 0, 8'hFF, 0);
    run("R4 read 126", OWN, 8'h03, 0, 126, 0, 8'hFF, 0);
    run("R4 read 125 ok", OWN, 8'h03, 0, 125, 0, 8'hFF, 0);
    run("R4 write 124", OWN, 8'h10, 0, 124, 0, 8'b0111_0111, 0);
    run("R4 write 123 ok", OWN, 8'h10, 0, 123, 0, 8'hFF, 0);
    for (int b = 0; b < 5; b++)
      run("R1 link error", OWN, 8'h06, 'h10, 0, 5'(1 << b), 8'hFF, 0);
    run("R2 foreign", 8'h22, 8'h06, 0, 1, 0, 8'hFF, 0);
    run("R2 foreign ok req", 8'h12, 8'h03, 0, 1, 0, 8'hFF, 0);
    run("R7 bcast no access", 8'h00, 8'h10, 'h20, 16, 0, 8'hFF, 0);
    run("R7 bcast bad func", 8'h00, 8'h05, 0, 1, 0, 8'hFF, 0);
    run("R7 bcast write ok", 8'h00, 8'h10, 'h30, 2, 0, 8'hFF, 0);
    run("R11 busy inject", OWN, 8'h03, 'h12, 10, 0, 8'hFF, 1);
    run("R11 busy inject exc", OWN, 8'h10, 'h20, 16, 0, 8'b0011_0011, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule